// File: doc/BRIEF.md
# SDRAM Write Burst Sequencer

This block is the write side of a controller for a single-data-rate SDRAM with a 16-bit data path. It takes one write request at a time. A request carries a bank, a start column, a burst length code and an auto-precharge flag. The block turns each request into a WRITE command on the chip pins and puts the first data word on DQ in the same cycle as that command. Each following word goes out on the next clock, and NOP commands fill the rest of the burst. The row is assumed to be open already.

Fixed bursts of 1, 2, 4 or 8 words end by themselves, after which DQ is released. A full-page burst keeps streaming, with the device wrapping inside the page, until a stop input issues a BURST TERMINATE. A new request can be accepted on any cycle. It cuts short whatever burst is running, so random writes can be issued back to back at full speed. All pin outputs are registered, so the pins show each cycle's decision one clock after the inputs that caused it.

Top module: `sdram_wr_seq`

## Requirements
- R1: While reset is asserted, the pins rest at cs_n, ras_n, cas_n and we_n all high, dq_oe low, dqm = 2'b11 and addr, ba and dq_out all zero.
- R2: A request is taken in a cycle where req_valid and wvalid are both high. req_ready equals wvalid once reset has been released. One clock later the pins show WRITE (cs_n=0, ras_n=1, cas_n=0, we_n=0), with the first word on dq_out, dq_oe high and dqm equal to wmask.
- R3: On a WRITE, addr[8:0] carries the column, ba carries the bank, addr[10] carries the auto-precharge flag, and every other addr bit is zero. On non-WRITE cycles, addr and ba are zero.
- R4: req_blen codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 words. Each word after the first is driven one clock after the previous one, with a NOP command (cs_n=0, the other three high).
- R5: Once a fixed burst has sent its last word, later cycles with no request show NOP with dq_oe low, dqm = 2'b11 and dq_out zero. Any offered data is left untaken (wready low).
- R6: A request accepted while a burst is running truncates it. The next pin cycle is the new WRITE with the new burst's first word, and the new burst's length then applies.
- R7: req_blen codes 4 to 7 select a full-page burst that never ends by itself. With such a burst running and no request, stop produces BURST TERMINATE (cs_n=0, ras_n=1, cas_n=1, we_n=0) with dq_oe low, and the burst ends.
- R8: stop has no effect when no full-page burst is running, whether the block is idle or in a fixed burst.
- R9: addr[10] is driven low on a WRITE that starts a full-page burst, even when the auto-precharge flag is set.
- R10: In a burst cycle with wvalid high, dqm equals wmask. In a burst cycle with wvalid low, the beat is still spent: dq_oe is high, dq_out is zero, dqm = 2'b11 and the burst advances.
- R11: wready is high exactly in the cycles that issue a WRITE or send a burst word.
- R12: After reset is released, every cycle with nothing to do shows NOP on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A write request is offered |
| req_ready | output | 1 | The request can be taken this cycle |
| req_bank | input | 2 | Target bank |
| req_col | input | 9 | Start column |
| req_blen | input | 3 | Burst code: 0..3 give 1/2/4/8 words, 4..7 give a full page |
| req_ap | input | 1 | Close the row when the burst ends |
| wvalid | input | 1 | A write data word is offered |
| wready | output | 1 | The data word is taken this cycle |
| wdata | input | 16 | Write data word |
| wmask | input | 2 | Byte mask for the word, 1 suppresses the byte |
| stop | input | 1 | End a running full-page burst |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | 13 | Address pins |
| ba | output | 2 | Bank pins |
| dq_out | output | 16 | Data driven onto DQ |
| dq_oe | output | 1 | DQ output enable |
| dqm | output | 2 | Byte mask pins |

## Verification
Directed runs come first. They cover one burst of each fixed length followed by trailing offered data, which separates a correct end of burst from an overrun. A WRITE is issued on every cycle across banks, which exposes any hidden gap or lost first word. A 600-word full-page burst with precharge requested shows whether the burst ends early at the page edge and whether the precharge bit is forced low. Stop is pulsed while idle and during fixed bursts, which tells an ignored stop from a stray terminate. Gaps in the data stream show whether an underrun beat is masked and still counted. A long seeded random mix of requests, stops, masks and data gaps then checks every pin against a bench model of the requirements.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_t;

  localparam cmd_t CMD_DESEL = cmd_t'(4'b1111);
  localparam cmd_t CMD_NOP   = cmd_t'(4'b0111);
  localparam cmd_t CMD_WRITE = cmd_t'(4'b0100);
  localparam cmd_t CMD_BST   = cmd_t'(4'b0110);

endpackage

// File: rtl/sdram_wr_beat_ctr.sv
module sdram_wr_beat_ctr #(
  parameter int REM_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REM_W-1:0] load_val,
  input  logic             step,
  output logic [REM_W-1:0] remain,
  output logic             last
);

  logic [REM_W-1:0] rem_q, rem_d;
  logic             rem_en;

  always_comb begin
    rem_en = load | step;
    rem_d  = rem_q;
    if (load)
      rem_d = load_val;
    else if (step)
      rem_d = rem_q - REM_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rem_q <= '0;
    else if (rem_en)
      rem_q <= rem_d;
  end

  assign remain = rem_q;
  assign last   = (rem_q == REM_W'(1));

endmodule

// File: rtl/sdram_wr_ctl.sv
module sdram_wr_ctl #(
  parameter int REM_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             req_valid,
  input  logic             wvalid,
  input  logic             req_full,
  input  logic [REM_W-1:0] req_rem,
  input  logic             stop,
  input  logic             last,
  output logic             issue_wr,
  output logic             issue_bst,
  output logic             beat,
  output logic             step_fixed,
  output logic             req_ready,
  output logic             wready
);

  logic act_q, act_d;
  logic full_q, full_d;

  always_comb begin
    req_ready  = run & wvalid;
    issue_wr   = req_ready & req_valid;
    issue_bst  = run & ~issue_wr & act_q & full_q & stop;
    beat       = run & ~issue_wr & ~issue_bst & act_q;
    step_fixed = beat & ~full_q;
    wready     = issue_wr | beat;

    act_d  = act_q;
    full_d = full_q;
    if (issue_wr) begin
      act_d  = req_full | (req_rem != '0);
      full_d = req_full;
    end else if (issue_bst) begin
      act_d  = 1'b0;
      full_d = 1'b0;
    end else if (step_fixed && last) begin
      act_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      full_q <= full_d;
    end
  end

endmodule

// File: rtl/sdram_wr_pins.sv
module sdram_wr_pins
  import sdram_wr_pkg::*;
#(
  parameter int DQ_W   = 16,
  parameter int COL_W  = 9,
  parameter int BA_W   = 2,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10,
  localparam int MASK_W = DQ_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              issue_wr,
  input  logic              issue_bst,
  input  logic              beat,
  input  logic              wvalid,
  input  logic [COL_W-1:0]  col,
  input  logic [BA_W-1:0]   bank,
  input  logic              ap,
  input  logic [DQ_W-1:0]   data,
  input  logic [MASK_W-1:0] mask,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic [MASK_W-1:0] dqm
);

  cmd_t              cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BA_W-1:0]   ba_q, ba_d;
  logic [DQ_W-1:0]   dq_q, dq_d;
  logic              oe_q, oe_d;
  logic [MASK_W-1:0] dqm_q, dqm_d;
  logic              word_ok;

  always_comb begin
    word_ok = issue_wr | (beat & wvalid);
    cmd_d   = CMD_NOP;
    if (!run)
      cmd_d = CMD_DESEL;
    else if (issue_wr)
      cmd_d = CMD_WRITE;
    else if (issue_bst)
      cmd_d = CMD_BST;

    addr_d = '0;
    ba_d   = '0;
    if (issue_wr) begin
      addr_d[COL_W-1:0] = col;
      addr_d[AP_BIT]    = ap;
      ba_d              = bank;
    end

    oe_d  = issue_wr | beat;
    dq_d  = word_ok ? data : '0;
    dqm_d = word_ok ? mask : '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_DESEL;
      addr_q <= '0;
      ba_q   <= '0;
      dq_q   <= '0;
      oe_q   <= 1'b0;
      dqm_q  <= '1;
    end else begin
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      ba_q   <= ba_d;
      dq_q   <= dq_d;
      oe_q   <= oe_d;
      dqm_q  <= dqm_d;
    end
  end

  assign cs_n   = cmd_q.cs_n;
  assign ras_n  = cmd_q.ras_n;
  assign cas_n  = cmd_q.cas_n;
  assign we_n   = cmd_q.we_n;
  assign addr   = addr_q;
  assign ba     = ba_q;
  assign dq_out = dq_q;
  assign dq_oe  = oe_q;
  assign dqm    = dqm_q;

endmodule

// File: rtl/sdram_wr_seq.sv
module sdram_wr_seq #(
  parameter int DQ_W       = 16,
  parameter int COL_W      = 9,
  parameter int BA_W       = 2,
  parameter int ADDR_W     = 13,
  parameter int AP_BIT     = 10,
  parameter int FIX_CODE_W = 2,
  localparam int BL_W      = FIX_CODE_W + 1,
  localparam int MASK_W    = DQ_W / 8,
  localparam int REM_W     = (1 << FIX_CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic [BL_W-1:0]   req_blen,
  input  logic              req_ap,
  input  logic              wvalid,
  output logic              wready,
  input  logic [DQ_W-1:0]   wdata,
  input  logic [MASK_W-1:0] wmask,
  input  logic              stop,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic [MASK_W-1:0] dqm
);

  logic             rs1_q, rs2_q;
  logic             run;
  logic             req_full;
  logic             ap_eff;
  logic [REM_W-1:0] req_rem;
  logic [REM_W-1:0] remain;
  logic             last;
  logic             issue_wr, issue_bst, beat, step_fixed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign run = rs2_q;

  always_comb begin
    req_full = req_blen[BL_W-1];
    ap_eff   = req_ap & ~req_full;
    req_rem  = REM_W'((1 << req_blen[FIX_CODE_W-1:0]) - 1);
  end

  sdram_wr_ctl #(.REM_W(REM_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .req_valid  (req_valid),
    .wvalid     (wvalid),
    .req_full   (req_full),
    .req_rem    (req_rem),
    .stop       (stop),
    .last       (last),
    .issue_wr   (issue_wr),
    .issue_bst  (issue_bst),
    .beat       (beat),
    .step_fixed (step_fixed),
    .req_ready  (req_ready),
    .wready     (wready)
  );

  sdram_wr_beat_ctr #(.REM_W(REM_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (issue_wr),
    .load_val (req_rem),
    .step     (step_fixed),
    .remain   (remain),
    .last     (last)
  );

  sdram_wr_pins #(
    .DQ_W   (DQ_W),
    .COL_W  (COL_W),
    .BA_W   (BA_W),
    .ADDR_W (ADDR_W),
    .AP_BIT (AP_BIT)
  ) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .issue_wr  (issue_wr),
    .issue_bst (issue_bst),
    .beat      (beat),
    .wvalid    (wvalid),
    .col       (req_col),
    .bank      (req_bank),
    .ap        (ap_eff),
    .data      (wdata),
    .mask      (wmask),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr      (addr),
    .ba        (ba),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .dqm       (dqm)
  );

endmodule

// File: rtl/sdram_wr_seq_chk.sv
module sdram_wr_seq_chk #(
  parameter int BL_W   = 3,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10,
  parameter int MASK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [BL_W-1:0]   req_blen,
  input logic              wvalid,
  input logic              wready,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic              dq_oe,
  input logic [MASK_W-1:0] dqm
);

  logic [3:0] pin_cmd;
  assign pin_cmd = {cs_n, ras_n, cas_n, we_n};

  AST_READY_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> wvalid);  // R2

  AST_TAKEN_GIVES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_ready) |-> (pin_cmd == 4'b0100));  // R6

  AST_WRITE_CARRIES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_cmd == 4'b0100) |-> dq_oe);  // R2

  AST_TERMINATE_RELEASES_DQ: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_cmd == 4'b0110) |-> !dq_oe);  // R7

  AST_FULL_PAGE_NO_AP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_ready && req_blen[BL_W-1]) |-> !addr[AP_BIT]);  // R9

  AST_TAKE_THEN_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wready) |-> dq_oe);  // R11

  AST_DRIVE_ONLY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(wready));  // R11

  AST_IDLE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dqm == '1));  // R5

endmodule

bind sdram_wr_seq sdram_wr_seq_chk #(
  .BL_W   (BL_W),
  .ADDR_W (ADDR_W),
  .AP_BIT (AP_BIT),
  .MASK_W (MASK_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_blen  (req_blen),
  .wvalid    (wvalid),
  .wready    (wready),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .addr      (addr),
  .dq_oe     (dq_oe),
  .dqm       (dqm)
);

// File: tb/tb_sdram_wr_seq.sv
module tb_sdram_wr_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_bank = '0;
  logic [8:0]  req_col = '0;
  logic [2:0]  req_blen = '0;
  logic        req_ap = 1'b0;
  logic        wvalid = 1'b0;
  logic        wready;
  logic [15:0] wdata = '0;
  logic [1:0]  wmask = '0;
  logic        stop = 1'b0;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [12:0] addr;
  logic [1:0]  ba;
  logic [15:0] dq_out;
  logic        dq_oe;
  logic [1:0]  dqm;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the requirements
  bit m_act = 0;
  bit m_full = 0;
  int m_rem = 0;
  logic [3:0]  e_cmd;
  logic [12:0] e_addr;
  logic [1:0]  e_ba;
  logic [15:0] e_dq;
  logic        e_oe;
  logic [1:0]  e_dqm;
  string t_cmd, t_addr, t_dq;

  always #2 clk = ~clk;

  sdram_wr_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_col(req_col), .req_blen(req_blen), .req_ap(req_ap),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wmask(wmask), .stop(stop),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba),
    .dq_out(dq_out), .dq_oe(dq_oe), .dqm(dqm)
  );

  task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, a, e);
    end
  endtask

  function automatic int burst_words(input logic [1:0] code);
    return 1 << code;
  endfunction

  task automatic step(input bit rv, input logic [1:0] b, input logic [8:0] c,
                      input logic [2:0] bl, input bit ap, input bit wv,
                      input logic [15:0] d, input logic [1:0] mk, input bit st);
    bit issue, bst, bt;
    req_valid = rv; req_bank = b; req_col = c; req_blen = bl; req_ap = ap;
    wvalid = wv; wdata = d; wmask = mk; stop = st;
    #1;
    issue = rv && wv;
    bst   = !issue && m_act && m_full && st;
    bt    = !issue && !bst && m_act;
    chk("R2 req_ready", {31'd0, req_ready}, {31'd0, wv});
    chk("R11 wready", {31'd0, wready}, {31'd0, issue || bt});
    e_addr = '0; e_ba = '0; e_dq = '0; e_oe = 1'b0; e_dqm = 2'b11;
    e_cmd = 4'b0111; t_addr = "R3"; t_dq = "R5";
    if (issue) begin
      e_cmd = 4'b0100;
      t_cmd = m_act ? "R6" : "R2";
      e_addr[8:0] = c;
      e_addr[10]  = ap && !bl[2];
      if (ap && bl[2]) t_addr = "R9";
      e_ba = b; e_dq = d; e_oe = 1'b1; e_dqm = mk; t_dq = "R2";
      m_full = bl[2];
      m_rem  = burst_words(bl[1:0]) - 1;
      m_act  = m_full || (m_rem != 0);
    end else if (bst) begin
      e_cmd = 4'b0110; t_cmd = "R7"; t_dq = "R7";
      m_act = 0; m_full = 0;
    end else if (bt) begin
      t_cmd = st ? "R8" : (m_full ? "R7" : "R4");
      e_oe = 1'b1;
      if (wv) begin e_dq = d; e_dqm = mk; t_dq = "R4"; end
      else t_dq = "R10";
      if (!m_full) begin
        m_rem--;
        m_act = (m_rem != 0);
      end
    end else begin
      t_cmd = st ? "R8" : "R12";
    end
    @(posedge clk);
    @(negedge clk);
    chk({t_cmd, " cmd"}, {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, e_cmd});
    chk({t_addr, " addr/ba"}, {17'd0, ba, addr}, {17'd0, e_ba, e_addr});
    chk({t_dq, " dq/oe"}, {15'd0, dq_oe, dq_out}, {15'd0, e_oe, e_dq});
    chk("R10 dqm", {30'd0, dqm}, {30'd0, e_dqm});
  endtask

  task automatic idle(input bit wv, input bit st);
    step(0, 2'd0, 9'd0, 3'd0, 0, wv, 16'($urandom), 2'b00, st);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 cmd", {28'd0, cs_n, ras_n, cas_n, we_n}, 32'hF);
    chk("R1 oe/dq", {15'd0, dq_oe, dq_out}, 32'd0);
    chk("R1 dqm", {30'd0, dqm}, 32'd3);
    chk("R1 addr/ba", {17'd0, ba, addr}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 cmd after reset", {28'd0, cs_n, ras_n, cas_n, we_n}, 32'h7);

    // R8: stop while idle
    idle(0, 1);
    idle(1, 1);

    // R4/R5: burst of 2 then trailing offered data
    step(1, 2'd1, 9'd37, 3'd1, 0, 1, 16'hA001, 2'b00, 0);
    idle(1, 0);
    idle(1, 0);
    idle(1, 0);

    // R4: each fixed length, with auto precharge (R3)
    for (int code = 0; code < 4; code++) begin
      step(1, 2'(code), 9'(100 + code), 3'(code), 1, 1, 16'(16'hB000 + code), 2'b00, 0);
      for (int k = 0; k < 9; k++) idle(1, 0);
    end

    // R6: write every cycle, changing banks and columns
    for (int k = 0; k < 12; k++)
      step(1, 2'(k), 9'(k * 7), 3'd3, 0, 1, 16'(16'hC000 + k), 2'(k), 0);
    for (int k = 0; k < 9; k++) idle(1, 0);

    // R7/R9: long full page with precharge requested, then stop
    step(1, 2'd2, 9'd508, 3'd7, 1, 1, 16'hD000, 2'b01, 0);
    for (int k = 0; k < 600; k++) idle(1, 0);
    idle(1, 1);
    idle(1, 0);

    // R8: stop during a fixed burst
    step(1, 2'd3, 9'd8, 3'd3, 0, 1, 16'hE000, 2'b00, 0);
    idle(1, 1);
    idle(1, 1);
    for (int k = 0; k < 7; k++) idle(1, 0);

    // R10: data gaps inside a burst
    step(1, 2'd0, 9'd4, 3'd2, 0, 1, 16'hF000, 2'b10, 0);
    idle(0, 0);
    idle(1, 0);
    idle(0, 0);
    idle(1, 0);

    // random mix
    for (int k = 0; k < 3000; k++) begin
      int pick;
      logic [2:0] bl;
      pick = int'($urandom % 5);
      bl = (pick == 4) ? 3'(4 + ($urandom % 4)) : 3'(pick);
      step(($urandom % 5) == 0, 2'($urandom), 9'($urandom), bl, 1'($urandom),
           ($urandom % 8) != 0, 16'($urandom), (($urandom % 4) == 0) ? 2'($urandom) : 2'b00,
           ($urandom % 10) == 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule